// File: doc/BRIEF.md
# Clock Post-Divider with Stepped Power-Down

This block turns a fast oscillator clock into a slower output clock. A 2-bit ratio code picks one of four power-of-two divisions. The output toggles from a single register, so the high and low phases are always equal. Ratio code `c` gives phases of `2^c` fast-clock cycles each. This is division by 1, 2, 4 or 8 of the half-rate base that the toggle register sets.

A power-down request slows the output by a further factor of 16. The block does not make this change in one jump. A ramp controller runs on a separate, slower reference clock and raises the extra exponent one step at a time (0 to 4). It holds each step for a programmable number of reference cycles, and it ramps back down the same way when the request is released. The step value crosses into the fast domain as a Gray code through a two-flop synchronizer. The output enable and the ratio code are synchronized the same way.

The ramp controller has four states:
- `RAMP_FULL`: settled at full speed.
- `RAMP_DOWN`: slowing.
- `RAMP_SLOW`: settled at one sixteenth.
- `RAMP_UP`: speeding up.

Its transitions are:
- FULL→DOWN when the request is seen.
- DOWN→SLOW when the last step's dwell ends.
- SLOW→UP when the request drops.
- UP→FULL when the first step's dwell ends.
- DOWN→UP or UP→DOWN when the request reverses mid-ramp.

The divider has three states:
- `DIV_PARK`: output held low.
- `DIV_HIGH`: high phase.
- `DIV_LOW`: low phase.

Its transitions are:
- PARK→HIGH on enable.
- HIGH→LOW at the end of the count.
- LOW→HIGH at the end of the count, which is where a new exponent is loaded.
- LOW→PARK when disabled.

Top module: `clk_postdiv_pd`

## Requirements
- R1: With power-down idle, ratio code `c` (0..3) makes every output phase last exactly `2^c` fast-clock cycles.
- R2: Every high phase of the output has the same length as the low phase that follows it.
- R3: Once a power-down entry has settled, every phase lasts `2^(c+4)` fast-clock cycles.
- R4: On power-down entry, the extra factor passes through 2, 4 and 8 before reaching 16. The ramp flag stays high for exactly 3×DWELL reference cycles.
- R5: On release, the extra factor returns through 8, 4 and 2 to 1 in four discrete steps. The ramp flag stays high for exactly 3×DWELL reference cycles.
- R6: While output enable is low, the output finishes any high phase and is then held low. On re-enable, it restarts with a full-length high phase.
- R7: A new ratio or step value takes effect only at the start of an output period. Every phase therefore has a power-of-two length and no runt pulse appears.
- R8: The ramp flag is low after reset and whenever the step is settled at 0 or 4, and high while a ramp is in progress.
- R9: The extra factor changes by one binary step at a time and never skips a step. The step value crosses clock domains as a Gray code.
- R10: A request that drops mid-ramp reverses the ramp from the current step, without first reaching the slowest factor.
- R11: During reset, the output is low and the ramp flag is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Fast oscillator clock driving the divider |
| ref_clk | input | 1 | Slow reference clock pacing the power-down ramp |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ratio_sel | input | 2 | Division code: phase length is 2^code fast cycles |
| pd_req | input | 1 | Power-down request, asynchronous to both clocks |
| out_en | input | 1 | Output enable; low parks the output low |
| clk_out | output | 1 | Divided clock output |
| ramp_busy | output | 1 | High while a power-down ramp is in progress (reference domain) |

## Verification
The bench builds the block with DWELL = 16 and two synchronizer stages. The reference clock runs ten times slower than the fast clock. Each ramp step therefore covers 160 fast cycles, which is many output periods at ratio code 0, so every intermediate factor on the way down and up shows up at the output pin. Ratio code 3 combined with a settled power-down takes the phase counter to its top value of 128. The dwell length also leaves room to reverse a ramp part-way through its second step.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int RATIO_W  = 2;
    localparam int PD_STEPS = 4;
    localparam int TOT_MAX  = ((1 << RATIO_W) - 1) + PD_STEPS;
    localparam int EXP_W    = $clog2(TOT_MAX + 1);

    typedef enum logic [1:0] {
        RAMP_FULL,
        RAMP_DOWN,
        RAMP_SLOW,
        RAMP_UP
    } ramp_state_t;

    typedef enum logic [1:0] {
        DIV_PARK,
        DIV_HIGH,
        DIV_LOW
    } div_state_t;

    function automatic logic [EXP_W-1:0] to_gray(input logic [EXP_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [EXP_W-1:0] from_gray(input logic [EXP_W-1:0] g);
        logic [EXP_W-1:0] b;
        b[EXP_W-1] = g[EXP_W-1];
        for (int i = EXP_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/cdc_sync.sv
module cdc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= '0;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pd_ramp_ctrl.sv
module pd_ramp_ctrl
    import clkdiv_pkg::*;
#(
    parameter int DWELL = 16
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             req_s,
    output logic [EXP_W-1:0] gray_o,
    output logic             busy_o
);

    localparam int CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DWELL - 1);
    localparam logic [EXP_W-1:0] EXP_TOP  = EXP_W'(PD_STEPS);
    localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(1);

    ramp_state_t      st_q, st_d;
    logic [EXP_W-1:0] exp_q, exp_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             dwell_end;

    assign dwell_end = (cnt_q == CNT_LAST);

    // state register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RAMP_FULL;
            exp_q <= '0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            exp_q <= exp_d;
            cnt_q <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        st_d  = st_q;
        exp_d = exp_q;
        cnt_d = cnt_q;
        unique case (st_q)
            RAMP_FULL: begin
                if (req_s) begin
                    st_d  = RAMP_DOWN;
                    exp_d = EXP_ONE;
                    cnt_d = '0;
                end
            end
            RAMP_DOWN: begin
                if (!req_s) begin
                    st_d  = RAMP_UP;
                    cnt_d = '0;
                end else if (dwell_end) begin
                    cnt_d = '0;
                    exp_d = exp_q + EXP_ONE;
                    if (exp_q + EXP_ONE == EXP_TOP) st_d = RAMP_SLOW;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            RAMP_SLOW: begin
                if (!req_s) begin
                    st_d  = RAMP_UP;
                    exp_d = EXP_TOP - EXP_ONE;
                    cnt_d = '0;
                end
            end
            RAMP_UP: begin
                if (req_s) begin
                    st_d  = RAMP_DOWN;
                    cnt_d = '0;
                end else if (dwell_end) begin
                    cnt_d = '0;
                    exp_d = exp_q - EXP_ONE;
                    if (exp_q == EXP_ONE) st_d = RAMP_FULL;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = RAMP_FULL;
        endcase
    end

    // registered outputs, computed from the next state
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            gray_o <= '0;
            busy_o <= 1'b0;
        end else begin
            gray_o <= to_gray(exp_d);
            busy_o <= (st_d == RAMP_DOWN) || (st_d == RAMP_UP);
        end
    end

    // step never leaves the 0..PD_STEPS range
    assert_exp_bounded_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        exp_q <= EXP_TOP);

    // one binary step per change, in either direction
    assert_single_step_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (exp_q != $past(exp_q)) |->
            ((exp_q == $past(exp_q) + EXP_ONE) || ($past(exp_q) == exp_q + EXP_ONE)));

    // settled flag only at the two end points
    assert_settled_ends_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !busy_o |-> ((exp_q == '0) || (exp_q == EXP_TOP)));

endmodule

// File: rtl/pow2_divider.sv
module pow2_divider
    import clkdiv_pkg::*;
(
    input  logic               fast_clk,
    input  logic               rst_n,
    input  logic               oe_s,
    input  logic [RATIO_W-1:0] ratio_s,
    input  logic [EXP_W-1:0]   pd_e,
    output logic               clk_o
);

    localparam int CNT_W = (TOT_MAX > 0) ? TOT_MAX : 1;

    div_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [EXP_W-1:0] cur_e_q, cur_e_d;
    logic [EXP_W-1:0] next_e;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] half_m1;
    logic             at_end;
    logic             out_q;

    assign next_e  = EXP_W'(ratio_s) + pd_e;
    assign span    = (CNT_W+1)'(1) << cur_e_q;
    assign half_m1 = CNT_W'(span - 1'b1);
    assign at_end  = (cnt_q == half_m1);

    // state register
    always_ff @(posedge fast_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= DIV_PARK;
            cnt_q   <= '0;
            cur_e_q <= '0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            cur_e_q <= cur_e_d;
        end
    end

    // next-state logic
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        cur_e_d = cur_e_q;
        unique case (st_q)
            DIV_PARK: begin
                cnt_d   = '0;
                cur_e_d = next_e;
                if (oe_s) st_d = DIV_HIGH;
            end
            DIV_HIGH: begin
                if (at_end) begin
                    st_d  = DIV_LOW;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            DIV_LOW: begin
                if (!oe_s) begin
                    st_d  = DIV_PARK;
                    cnt_d = '0;
                end else if (at_end) begin
                    st_d    = DIV_HIGH;
                    cnt_d   = '0;
                    cur_e_d = next_e;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = DIV_PARK;
        endcase
    end

    // output register
    always_ff @(posedge fast_clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= (st_d == DIV_HIGH);
    end

    assign clk_o = out_q;

    // disabled and low: stays low
    assert_park_low_R6: assert property (@(posedge fast_clk) disable iff (!rst_n)
        (!oe_s && !out_q) |=> !out_q);

    // exponent only reloads while the output was low (start of a period)
    assert_period_start_R7: assert property (@(posedge fast_clk) disable iff (!rst_n)
        (cur_e_q != $past(cur_e_q)) |-> !$past(out_q));

    // phase counter never runs past the current phase length
    assert_no_overrun_R2: assert property (@(posedge fast_clk) disable iff (!rst_n)
        cnt_q <= half_m1);

endmodule

// File: rtl/clk_postdiv_pd.sv
module clk_postdiv_pd
    import clkdiv_pkg::*;
#(
    parameter int DWELL       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               fast_clk,
    input  logic               ref_clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_sel,
    input  logic               pd_req,
    input  logic               out_en,
    output logic               clk_out,
    output logic               ramp_busy
);

    logic                 req_s;
    logic [EXP_W-1:0]     gray_r;
    logic [EXP_W-1:0]     gray_f;
    logic [EXP_W-1:0]     pd_e;
    logic [RATIO_W:0]     ctl_s;

    cdc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (pd_req),
        .q     (req_s)
    );

    pd_ramp_ctrl #(.DWELL(DWELL)) u_ramp (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .req_s   (req_s),
        .gray_o  (gray_r),
        .busy_o  (ramp_busy)
    );

    cdc_sync #(.W(EXP_W), .STAGES(SYNC_STAGES)) u_step_sync (
        .clk   (fast_clk),
        .rst_n (rst_n),
        .d     (gray_r),
        .q     (gray_f)
    );

    cdc_sync #(.W(RATIO_W + 1), .STAGES(SYNC_STAGES)) u_ctl_sync (
        .clk   (fast_clk),
        .rst_n (rst_n),
        .d     ({out_en, ratio_sel}),
        .q     (ctl_s)
    );

    assign pd_e = from_gray(gray_f);

    pow2_divider u_div (
        .fast_clk (fast_clk),
        .rst_n    (rst_n),
        .oe_s     (ctl_s[RATIO_W]),
        .ratio_s  (ctl_s[RATIO_W-1:0]),
        .pd_e     (pd_e),
        .clk_o    (clk_out)
    );

    // Gray step reaches the fast domain one bit change at a time
    assert_gray_one_bit_R9: assert property (@(posedge fast_clk) disable iff (!rst_n)
        $countones(gray_f ^ $past(gray_f)) <= 1);

endmodule

// File: tb/tb_clk_postdiv_pd.sv
module tb_clk_postdiv_pd;

    localparam int DWELL = 16;

    logic       fast_clk = 1'b0;
    logic       ref_clk  = 1'b0;
    logic       rst_n    = 1'b0;
    logic [1:0] ratio_sel = 2'd0;
    logic       pd_req   = 1'b0;
    logic       out_en   = 1'b0;
    logic       clk_out;
    logic       ramp_busy;

    always #10  fast_clk = ~fast_clk;
    always #100 ref_clk  = ~ref_clk;

    clk_postdiv_pd #(.DWELL(DWELL), .SYNC_STAGES(2)) dut (
        .fast_clk  (fast_clk),
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .ratio_sel (ratio_sel),
        .pd_req    (pd_req),
        .out_en    (out_en),
        .clk_out   (clk_out),
        .ramp_busy (ramp_busy)
    );

    int vectors = 0;
    int errors  = 0;

    // behavioural model: queue of completed phase lengths seen at the pin
    int   runs[$];
    int   run_len   = 0;
    logic last_lvl  = 1'b0;
    int   high_len  = 0;
    bit   have_high = 1'b0;
    bit   skip      = 1'b1;
    bit   mon_on    = 1'b0;

    int busy_run  = 0;
    int busy_len  = 0;
    int busy_done = 0;

    task automatic check(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // every fast cycle: track phases, check R2 pairing and R7 power-of-two lengths
    always @(negedge fast_clk) begin
        if (mon_on) begin
            if (!out_en) skip = 1'b1;
            if (clk_out === last_lvl) begin
                run_len++;
            end else begin
                if (!skip) begin
                    runs.push_back(run_len);
                    check(((run_len & (run_len - 1)) == 0) && run_len <= 128,
                          "R7 phase power of two", run_len, run_len);
                end
                if (last_lvl) begin
                    high_len  = run_len;
                    have_high = !skip;
                end else begin
                    if (have_high && !skip)
                        check(high_len == run_len, "R2 high equals low", run_len, high_len);
                    skip = 1'b0;
                end
                last_lvl = clk_out;
                run_len  = 1;
            end
        end
    end

    always @(negedge ref_clk) begin
        if (ramp_busy) begin
            busy_run++;
        end else if (busy_run != 0) begin
            busy_len  = busy_run;
            busy_run  = 0;
            busy_done++;
        end
    end

    task automatic fast_cycles(int n);
        repeat (n) @(negedge fast_clk);
    endtask

    task automatic collect(int n);
        while (runs.size() < n) @(negedge fast_clk);
    endtask

    task automatic wait_busy(int prev);
        while (busy_done == prev) @(negedge fast_clk);
    endtask

    task automatic steady(int half, string req);
        fast_cycles(600);
        runs.delete();
        collect(6);
        for (int i = 0; i < 6; i++) check(runs[i] == half, req, runs[i], half);
    endtask

    task automatic check_seq(int e0, int e1, int e2, int e3, int e4, string req);
        int ded[$];
        int expv[5];
        expv = '{e0, e1, e2, e3, e4};
        foreach (runs[i]) begin
            if (ded.size() == 0 || ded[ded.size()-1] != runs[i]) ded.push_back(runs[i]);
        end
        check(ded.size() == 5, req, ded.size(), 5);
        for (int i = 0; i < 5 && i < ded.size(); i++) check(ded[i] == expv[i], req, ded[i], expv[i]);
        for (int i = 1; i < ded.size(); i++)
            check((ded[i] == 2 * ded[i-1]) || (ded[i-1] == 2 * ded[i]),
                  "R9 single binary step", ded[i], ded[i-1]);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge fast_clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int prev;
        int mx;
        int lowcnt;
        // R11 reset state
        fast_cycles(5);
        check(clk_out == 1'b0, "R11 output low in reset", clk_out, 0);
        check(ramp_busy == 1'b0, "R11 busy low in reset", ramp_busy, 0);
        check(ramp_busy == 1'b0, "R8 busy low after reset", ramp_busy, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        fast_cycles(50);
        check(clk_out == 1'b0, "R6 parked while disabled", clk_out, 0);

        // R1 each ratio code
        out_en = 1'b1;
        for (int r = 0; r < 4; r++) begin
            ratio_sel = 2'(r);
            steady(1 << r, "R1 divide ratio");
        end
        ratio_sel = 2'd0;
        fast_cycles(600);

        // R4 entry ramp
        prev = busy_done;
        runs.delete();
        pd_req = 1'b1;
        wait_busy(prev);
        check(busy_len == 3 * DWELL, "R4 entry busy length", busy_len, 3 * DWELL);
        fast_cycles(600);
        check_seq(1, 2, 4, 8, 16, "R4 entry factors");
        check(ramp_busy == 1'b0, "R8 busy low when slow", ramp_busy, 0);

        // R3 settled power-down
        steady(16, "R3 slow ratio 0");
        ratio_sel = 2'd3;
        steady(128, "R3 slow ratio 3");
        ratio_sel = 2'd0;
        fast_cycles(600);

        // R5 exit ramp
        prev = busy_done;
        runs.delete();
        pd_req = 1'b0;
        wait_busy(prev);
        check(busy_len == 3 * DWELL, "R5 exit busy length", busy_len, 3 * DWELL);
        fast_cycles(600);
        check_seq(16, 8, 4, 2, 1, "R5 exit factors");
        check(ramp_busy == 1'b0, "R8 busy low when full", ramp_busy, 0);

        // R10 reversal mid-ramp
        prev = busy_done;
        runs.delete();
        pd_req = 1'b1;
        repeat (20) @(negedge ref_clk);
        check(ramp_busy == 1'b1, "R8 busy high mid-ramp", ramp_busy, 1);
        pd_req = 1'b0;
        wait_busy(prev);
        fast_cycles(400);
        mx = 0;
        foreach (runs[i]) if (runs[i] > mx) mx = runs[i];
        check(mx == 4, "R10 reversal peak factor", mx, 4);
        check(runs[runs.size()-1] == 1, "R10 back to full", runs[runs.size()-1], 1);

        // R6 disable and re-enable
        ratio_sel = 2'd2;
        fast_cycles(600);
        out_en = 1'b0;
        fast_cycles(20);
        lowcnt = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge fast_clk);
            if (clk_out == 1'b0) lowcnt++;
        end
        check(lowcnt == 300, "R6 held low while disabled", lowcnt, 300);
        runs.delete();
        out_en = 1'b1;
        collect(2);
        check(runs[0] == 4, "R6 first high after enable", runs[0], 4);
        check(runs[1] == 4, "R6 first low after enable", runs[1], 4);

        finish_run();
    end

endmodule